// File: doc/BRIEF.md
# Dual Down-Counting Timer

This block holds two independent down-counters behind a small register window. Each counter has a reload value, a live count, a control byte and an interrupt flag. It decrements on a strobe derived from an external tick-enable input. A per-timer prescaler passes every tick, every 16th tick or every 256th tick.

Each counter can run 32 bits wide or only in its low 16 bits. It has three counting modes:
- Periodic: the counter restarts from its reload value.
- Free-running: the counter wraps to all ones.
- One-shot: the counter parks at zero.

Software can change the reload value without disturbing the count in progress. Each timer raises a flag when its count reaches zero. The flag can be masked per timer, and the masked flags are ORed into one interrupt line.

The register port is a plain single-cycle access with no back-pressure. A write is taken on the clock edge where `reg_we` is high. Read data is a combinational function of `reg_addr`. Each timer owns a 32-byte slot, so timer n starts at byte address 0x20·n. The offsets within a slot are:
- 0x00: reload value, which also sets the count.
- 0x04: live count.
- 0x08: control byte.
- 0x0C: flag clear.
- 0x10: raw flag.
- 0x14: masked flag.
- 0x18: reload value only.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, each timer's count and reload value read 0xFFFFFFFF, its control byte reads 0x20 (flag enable set, counting off), its raw flag is 0, and `irq_out` is low.
- R2: A write to offset 0x00 sets both the reload value and the count on the next edge. A write to offset 0x18 sets only the reload value and leaves the count unchanged; both offsets read back the reload value.
- R3: The count changes only on a prescaled tick while control bit 7 (enable) is 1; with bit 7 at 0, ticks leave the count unchanged.
- R4: A step that takes the active part of the count from 1 to 0 sets that timer's raw flag, readable as bit 0 of offset 0x10.
- R5: In periodic mode (bit 6 = 1, bit 0 = 0), a step taken at zero copies the current reload value into the count, so a reload value N gives a period of N+1 steps.
- R6: In free-running mode (bit 6 = 0, bit 0 = 0), a step taken at zero sets the active part of the count to all ones (0xFFFFFFFF in 32-bit mode, low half 0xFFFF in 16-bit mode).
- R7: In one-shot mode (bit 0 = 1, regardless of bit 6), the count stays at zero and raises no further flag until the reload value is written.
- R8: With bit 1 at 0 (16-bit mode), only bits 15:0 count and test for zero, and bits 31:16 hold their value; with bit 1 at 1 all 32 bits count.
- R9: Control bits 3:2 select the prescale: 00 divides ticks by 1, 01 by 16, and 10 or 11 by 256. The prescaler restarts from zero whenever the timer is disabled.
- R10: Any write to offset 0x0C clears the raw flag on the next edge, except that a flag set by a step on the same edge wins.
- R11: The masked flag at offset 0x14 and `timer_irq[n]` equal the raw flag ANDed with control bit 5; `irq_out` is the OR of all `timer_irq` bits.
- R12: Writes to offsets 0x04, 0x10 and 0x14 have no effect. Unused offsets read 0. Control bit 4 and bits 31:8 read 0. A write to one timer's slot never alters the other timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | NUM_TIMERS | Per-timer timing-reference strobe, one tick per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address; top bits pick the timer, low 5 bits the offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| timer_irq | output | NUM_TIMERS | Per-timer masked flag |
| irq_out | output | 1 | OR of all masked flags |

## Verification
The bench goes after the edges of the count.

- A design that flagged one step late, or reloaded on the step that reaches zero, would show the wrong count or flag at the step-by-step reads.
- A 16-bit design that borrowed into the upper half, or wrapped the whole word, would corrupt 0x1234xxxx.
- A prescaler off by one tick, or one that treated code 11 as divide-by-1, would move the count on tick 15 or 255.
- A design whose background write touched the count, or whose flag clear beat a simultaneous zero-crossing, would lose the reload value or drop an event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int OFS_W = 5;

  // Control byte layout; the bit positions are the software-visible encoding.
  typedef struct packed {
    logic       run;       // 7
    logic       periodic;  // 6
    logic       flag_en;   // 5
    logic       spare;     // 4, reads 0
    logic [1:0] presc;     // 3:2
    logic       wide;      // 1
    logic       single;    // 0
  } tmr_ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;
  localparam logic [7:0] CTRL_WMASK = 8'hEF;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV16  = 2'b01,
    PS_DIV256 = 2'b10,
    PS_DIV256X = 2'b11
  } presc_e;

  localparam logic [OFS_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [OFS_W-1:0] OFS_COUNT  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [OFS_W-1:0] OFS_ACK    = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_RAW    = 5'h10;
  localparam logic [OFS_W-1:0] OFS_MASKED = 5'h14;
  localparam logic [OFS_W-1:0] OFS_BGREL  = 5'h18;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRESC_BITS = 8,
  localparam int MID_BITS = PRESC_BITS / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       step
);

  logic [PRESC_BITS-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      stage_q <= '0;
    end else if (tick) begin
      stage_q <= stage_q + PRESC_BITS'(1);
    end
  end

  always_comb begin
    unique case (presc_e'(sel))
      PS_DIV1:  step = run && tick;
      PS_DIV16: step = run && tick && (&stage_q[MID_BITS-1:0]);
      default:  step = run && tick && (&stage_q);
    endcase
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              single,
  input  logic              periodic,
  input  logic              wide,
  input  logic              wr_reload,
  input  logic              wr_bg,
  input  logic              ack,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] reload,
  output logic              raw
);

  logic [HALF_W-1:0] low;
  logic              at_zero;
  logic              at_one;
  logic [DATA_W-1:0] count_nx;
  logic              hit_zero;

  assign low = count[HALF_W-1:0];

  always_comb begin
    if (wide) begin
      at_zero = (count == '0);
      at_one  = (count == DATA_W'(1));
    end else begin
      at_zero = (low == '0);
      at_one  = (low == HALF_W'(1));
    end
  end

  always_comb begin
    count_nx = count;
    hit_zero = 1'b0;
    if (at_zero) begin
      if (single)        count_nx = count;
      else if (periodic) count_nx = reload;
      else if (wide)     count_nx = '1;
      else               count_nx = {count[DATA_W-1:HALF_W], {HALF_W{1'b1}}};
    end else begin
      if (wide) count_nx = count - DATA_W'(1);
      else      count_nx = {count[DATA_W-1:HALF_W], low - HALF_W'(1)};
      hit_zero = at_one;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '1;
      reload <= '1;
      raw    <= 1'b0;
    end else begin
      if (wr_reload) begin
        count  <= wdata;
        reload <= wdata;
      end else begin
        if (step)  count  <= count_nx;
        if (wr_bg) reload <= wdata;
      end
      if (step && hit_zero) raw <= 1'b1;
      else if (ack)         raw <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W = 32,
  parameter int SEL_W = 1,
  localparam int ADDR_W = SEL_W + OFS_W
) (
  input  logic                                 reg_we,
  input  logic [ADDR_W-1:0]                    reg_addr,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0]    cnt_i,
  input  logic [NUM_TIMERS-1:0][DATA_W-1:0]    rel_i,
  input  logic [NUM_TIMERS-1:0][7:0]           ctrl_i,
  input  logic [NUM_TIMERS-1:0]                raw_i,
  input  logic [NUM_TIMERS-1:0]                msk_i,
  output logic [NUM_TIMERS-1:0]                wr_reload,
  output logic [NUM_TIMERS-1:0]                wr_bg,
  output logic [NUM_TIMERS-1:0]                wr_ctrl,
  output logic [NUM_TIMERS-1:0]                wr_ack,
  output logic [DATA_W-1:0]                    rdata
);

  logic [SEL_W-1:0] sel;
  logic [OFS_W-1:0] ofs;

  assign sel = reg_addr[ADDR_W-1:OFS_W];
  assign ofs = reg_addr[OFS_W-1:0];

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dec
    logic hit;
    assign hit          = reg_we && (sel == SEL_W'(i));
    assign wr_reload[i] = hit && (ofs == OFS_RELOAD);
    assign wr_bg[i]     = hit && (ofs == OFS_BGREL);
    assign wr_ctrl[i]   = hit && (ofs == OFS_CTRL);
    assign wr_ack[i]    = hit && (ofs == OFS_ACK);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (sel == SEL_W'(i)) begin
        unique case (ofs)
          OFS_RELOAD, OFS_BGREL: rdata = rel_i[i];
          OFS_COUNT:             rdata = cnt_i[i];
          OFS_CTRL:              rdata = {{(DATA_W-8){1'b0}}, ctrl_i[i]};
          OFS_RAW:               rdata = {{(DATA_W-1){1'b0}}, raw_i[i]};
          OFS_MASKED:            rdata = {{(DATA_W-1){1'b0}}, msk_i[i]};
          default:               rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W = 32,
  parameter int PRESC_BITS = 8,
  localparam int SEL_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W = SEL_W + OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TIMERS-1:0] tick_en,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_TIMERS-1:0] timer_irq,
  output logic                  irq_out
);

  tmr_ctrl_t [NUM_TIMERS-1:0]             ctrl_q;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]      cur_val;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]      rel_val;
  logic [NUM_TIMERS-1:0][7:0]             ctrl_bits;
  logic [NUM_TIMERS-1:0]                  raw_q;
  logic [NUM_TIMERS-1:0]                  en_q;
  logic [NUM_TIMERS-1:0]                  single_q;
  logic [NUM_TIMERS-1:0]                  ie_q;
  logic [NUM_TIMERS-1:0]                  wr_reload;
  logic [NUM_TIMERS-1:0]                  wr_bg;
  logic [NUM_TIMERS-1:0]                  wr_ctrl;
  logic [NUM_TIMERS-1:0]                  wr_ack;
  logic [NUM_TIMERS-1:0]                  step;

  tmr_regif #(
    .NUM_TIMERS(NUM_TIMERS),
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W)
  ) u_regif (
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .cnt_i    (cur_val),
    .rel_i    (rel_val),
    .ctrl_i   (ctrl_bits),
    .raw_i    (raw_q),
    .msk_i    (timer_irq),
    .wr_reload(wr_reload),
    .wr_bg    (wr_bg),
    .wr_ctrl  (wr_ctrl),
    .wr_ack   (wr_ack),
    .rdata    (reg_rdata)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[i] <= tmr_ctrl_t'(CTRL_RESET);
      end else if (wr_ctrl[i]) begin
        ctrl_q[i] <= tmr_ctrl_t'(reg_wdata[7:0] & CTRL_WMASK);
      end
    end

    assign ctrl_bits[i] = ctrl_q[i];
    assign en_q[i]      = ctrl_q[i].run;
    assign single_q[i]  = ctrl_q[i].single;
    assign ie_q[i]      = ctrl_q[i].flag_en;

    tmr_prescaler #(
      .PRESC_BITS(PRESC_BITS)
    ) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl_q[i].run),
      .tick (tick_en[i]),
      .sel  (ctrl_q[i].presc),
      .step (step[i])
    );

    tmr_core #(
      .DATA_W(DATA_W)
    ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step[i]),
      .single   (ctrl_q[i].single),
      .periodic (ctrl_q[i].periodic),
      .wide     (ctrl_q[i].wide),
      .wr_reload(wr_reload[i]),
      .wr_bg    (wr_bg[i]),
      .ack      (wr_ack[i]),
      .wdata    (reg_wdata),
      .count    (cur_val[i]),
      .reload   (rel_val[i]),
      .raw      (raw_q[i])
    );

    assign timer_irq[i] = raw_q[i] & ctrl_q[i].flag_en;
  end

  assign irq_out = |timer_irq;

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_TIMERS-1:0]              tick_en,
  input logic                               reg_we,
  input logic [ADDR_W-1:0]                  reg_addr,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0]  cur_val,
  input logic [NUM_TIMERS-1:0]              raw_q,
  input logic [NUM_TIMERS-1:0]              en_q,
  input logic [NUM_TIMERS-1:0]              single_q,
  input logic [NUM_TIMERS-1:0]              ie_q,
  input logic [NUM_TIMERS-1:0]              timer_irq
);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    logic wr_hit;
    assign wr_hit = reg_we && (int'(reg_addr[ADDR_W-1:5]) == i);

    // R3: no tick and no write to this slot keeps the count
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en[i] && !wr_hit) |=> $stable(cur_val[i]));

    // R4: arriving at zero by counting raises the raw flag
    a_r4_zero_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_val[i] == '0 && $past(cur_val[i]) != '0 && !$past(wr_hit)) |-> raw_q[i]);

    // R7: an enabled one-shot timer parked at zero stays there
    a_r7_single_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && single_q[i] && cur_val[i] == '0 && !wr_hit) |=> (cur_val[i] == '0));

    // R10: a flag clear with no tick leaves the flag low
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && reg_addr[4:0] == 5'h0C && !tick_en[i]) |=> !raw_q[i]);

    // R11: a masked timer never drives its interrupt
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q[i] |-> !timer_irq[i]);
  end

endmodule

bind dual_countdown_timer dct_checker #(
  .NUM_TIMERS(NUM_TIMERS),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_dct_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .cur_val  (cur_val),
  .raw_q    (raw_q),
  .en_q     (en_q),
  .single_q (single_q),
  .ie_q     (ie_q),
  .timer_irq(timer_irq)
);

// File: tb/test_dual_countdown_timer.sv
module test_dual_countdown_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tick_en = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  timer_irq;
  logic        irq_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_countdown_timer i_dual_countdown_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .timer_irq(timer_irq),
    .irq_out  (irq_out)
  );

  // {write, addr, wdata, expected read}; row tags: R2 and R12
  localparam logic [70:0] VEC [0:NVEC-1] = '{
    {1'b1, 6'h08, 32'h0000_0000, 32'h0},           // R12 disable timer 0
    {1'b0, 6'h08, 32'h0,         32'h0000_0000},   // R12 ctrl readback
    {1'b1, 6'h00, 32'h0000_ABCD, 32'h0},           // R2 reload write
    {1'b0, 6'h04, 32'h0,         32'h0000_ABCD},   // R2 count follows
    {1'b0, 6'h00, 32'h0,         32'h0000_ABCD},   // R2 reload readback
    {1'b1, 6'h18, 32'h0000_1111, 32'h0},           // R2 background write
    {1'b0, 6'h04, 32'h0,         32'h0000_ABCD},   // R2 count untouched
    {1'b0, 6'h18, 32'h0,         32'h0000_1111},   // R2 reload via 0x18
    {1'b0, 6'h00, 32'h0,         32'h0000_1111},   // R2 reload via 0x00
    {1'b1, 6'h08, 32'hFFFF_FFFF, 32'h0},           // R12 all-ones ctrl
    {1'b0, 6'h08, 32'h0,         32'h0000_00EF},   // R12 bit 4 and top bits read 0
    {1'b1, 6'h04, 32'h0000_0055, 32'h0},           // R12 write to count ignored
    {1'b0, 6'h04, 32'h0,         32'h0000_ABCD},   // R12
    {1'b1, 6'h30, 32'h0000_0001, 32'h0},           // R12 write to raw ignored
    {1'b1, 6'h28, 32'h0000_00C2, 32'h0},           // R12 timer 1 ctrl
    {1'b0, 6'h28, 32'h0,         32'h0000_00C2},   // R12
    {1'b0, 6'h08, 32'h0,         32'h0000_00EF},   // R12 timer 0 unaffected
    {1'b0, 6'h3C, 32'h0,         32'h0000_0000}    // R12 unused offset reads 0
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic ticks(input int t, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_en[t] = 1'b1;
      @(negedge clk); tick_en[t] = 1'b0;
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h04, 32'hFFFF_FFFF, "R1 count");
    rd(6'h00, 32'hFFFF_FFFF, "R1 reload");
    rd(6'h08, 32'h0000_0020, "R1 ctrl");
    rd(6'h10, 32'h0, "R1 raw");
    rd(6'h24, 32'hFFFF_FFFF, "R1 timer1 count");
    chk(32'(irq_out), 32'h0, "R1 irq_out");

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][70]) wr(VEC[k][69:64], VEC[k][63:32]);
      else rd(VEC[k][69:64], VEC[k][31:0], $sformatf("R2/R12 row %0d", k));
    end
    wr(6'h08, 32'h0);
    wr(6'h28, 32'h0);

    // periodic 32-bit: R4, R5, R11
    wr(6'h00, 32'd3);
    wr(6'h08, 32'hE2);
    ticks(0, 2);
    rd(6'h04, 32'd1, "R3 decrement");
    rd(6'h10, 32'h0, "R4 no flag before zero");
    ticks(0, 1);
    rd(6'h04, 32'd0, "R4 count zero");
    rd(6'h10, 32'h1, "R4 raw set");
    rd(6'h14, 32'h1, "R11 masked set");
    chk(32'(irq_out), 32'h1, "R11 irq_out");
    chk(32'(timer_irq), 32'h1, "R11 timer_irq");
    ticks(0, 1);
    rd(6'h04, 32'd3, "R5 reload");
    wr(6'h0C, 32'hDEAD);
    rd(6'h10, 32'h0, "R10 ack clears");
    chk(32'(irq_out), 32'h0, "R10 irq_out low");

    // R3 disabled timer ignores ticks
    wr(6'h08, 32'h62);
    ticks(0, 3);
    rd(6'h04, 32'd3, "R3 disabled holds");

    // R11 masked flag
    wr(6'h08, 32'hC2);
    ticks(0, 3);
    rd(6'h10, 32'h1, "R11 raw with mask off");
    rd(6'h14, 32'h0, "R11 masked off");
    chk(32'(irq_out), 32'h0, "R11 irq_out masked");
    wr(6'h0C, 32'h0);
    ticks(0, 3);
    rd(6'h04, 32'd1, "R5 period");
    // R10 set and clear on the same edge: set wins
    @(negedge clk);
    tick_en[0] = 1'b1; reg_we = 1'b1; reg_addr = 6'h0C; reg_wdata = 32'h0;
    @(negedge clk);
    tick_en[0] = 1'b0; reg_we = 1'b0;
    rd(6'h04, 32'd0, "R10 count zero");
    rd(6'h10, 32'h1, "R10 set wins");
    wr(6'h0C, 32'h0);

    // R8 / R6 16-bit free-running
    wr(6'h08, 32'h0);
    wr(6'h00, 32'h1234_0002);
    wr(6'h08, 32'hA0);
    ticks(0, 2);
    rd(6'h04, 32'h1234_0000, "R8 low half zero");
    rd(6'h10, 32'h1, "R4 raw in 16-bit");
    ticks(0, 1);
    rd(6'h04, 32'h1234_FFFF, "R6 R8 16-bit wrap");
    wr(6'h0C, 32'h0);

    // R6 32-bit free-running
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd1);
    wr(6'h08, 32'hA2);
    ticks(0, 1);
    rd(6'h04, 32'd0, "R6 at zero");
    ticks(0, 1);
    rd(6'h04, 32'hFFFF_FFFF, "R6 32-bit wrap");
    wr(6'h0C, 32'h0);

    // R7 one-shot overrides periodic
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd2);
    wr(6'h08, 32'hE3);
    ticks(0, 2);
    rd(6'h10, 32'h1, "R7 raw");
    wr(6'h0C, 32'h0);
    ticks(0, 3);
    rd(6'h04, 32'd0, "R7 parked");
    rd(6'h10, 32'h0, "R7 no second flag");

    // R2 / R5 background reload
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd4);
    wr(6'h08, 32'hE2);
    ticks(0, 1);
    wr(6'h18, 32'd9);
    rd(6'h04, 32'd3, "R2 bg keeps count");
    rd(6'h00, 32'd9, "R2 bg reload");
    ticks(0, 3);
    rd(6'h04, 32'd0, "R2 runs to zero");
    ticks(0, 1);
    rd(6'h04, 32'd9, "R5 uses new reload");
    wr(6'h0C, 32'h0);

    // R9 prescaler
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd10);
    wr(6'h08, 32'hE6);
    ticks(0, 15);
    rd(6'h04, 32'd10, "R9 div16 before");
    ticks(0, 1);
    rd(6'h04, 32'd9, "R9 div16 step");
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd10);
    wr(6'h08, 32'hEA);
    ticks(0, 255);
    rd(6'h04, 32'd10, "R9 div256 before");
    ticks(0, 1);
    rd(6'h04, 32'd9, "R9 div256 step");
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd10);
    wr(6'h08, 32'hEE);
    ticks(0, 255);
    rd(6'h04, 32'd10, "R9 code 11 before");
    ticks(0, 1);
    rd(6'h04, 32'd9, "R9 code 11 step");

    // R12 timer 1 slot, independence
    wr(6'h08, 32'h0);
    wr(6'h20, 32'd2);
    wr(6'h28, 32'hE2);
    ticks(1, 2);
    rd(6'h24, 32'd0, "R12 timer1 count");
    rd(6'h30, 32'h1, "R12 timer1 raw");
    chk(32'(timer_irq), 32'h2, "R11 timer1 irq");
    chk(32'(irq_out), 32'h1, "R11 irq_out from timer1");
    rd(6'h04, 32'd9, "R12 timer0 unaffected");
    rd(6'h10, 32'h0, "R12 timer0 raw clear");
    wr(6'h2C, 32'h0);
    chk(32'(irq_out), 32'h0, "R10 timer1 ack");

    summary();
  end

endmodule